// File: doc/BRIEF.md
# MDIO Management Frame Controller with Command-Word Interface

This block lets a host reach the management registers of an external Ethernet PHY over a two-wire MDIO link without handling the serial protocol itself. The host sees two 32-bit words behind a small register bus: a data word and a command word. Writing the command word starts one Clause-22 management frame, either a read or a write. The PHY address, the register index and the direction are all packed into that command word.

The busy flag in the command word stays set for the whole serial frame. The host polls it until it clears. For a write, the host first stores the 16-bit value in the data word and then issues the command. For a read, the host issues the command, waits for busy to drop, and then finds the PHY's answer in the low half of the data word. The block makes the management clock by dividing the system clock. It drives the data pin and releases it to high impedance when the PHY has to answer, and it shifts in the PHY's reply. A PHY that never answers leaves the pulled-up line high, so the read returns all ones.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the data word reads 0, the command word reads 0, the clock output is low, and the data pin is not driven (output enable 0).
- R2: The command word (address 1) holds the PHY address in bits [15:11], the register index in bits [10:6] and the direction in bit 1 (1 = write, 0 = read). Bit 0 reads as the busy flag, bits [31:16] and [5:2] read as 0. The data word is address 0.
- R3: A write to the command word while idle makes busy read 1 on the very next cycle. Busy stays 1 for exactly 64 management-clock periods and drops at the clock edge where the last low-going management-clock edge occurs.
- R4: The management clock has a period of CLK_DIV system cycles (default 40). Each period has CLK_DIV/2 cycles low followed by CLK_DIV/2 cycles high, and a frame starts on a low phase. The clock stays low whenever the block is idle.
- R5: A frame goes out MSB first as follows: 32 ones, then 0 and 1, then opcode 1,0 for a read or 0,1 for a write, then the 5 PHY-address bits, then the 5 register-index bits. The data pin only changes when the management clock falls or when a frame starts.
- R6: In a write frame the block drives the pin for all 64 bit times. The turnaround bits are 1 then 0, followed by data-word bits [15:0] MSB first. The output enable is 0 whenever the block is idle.
- R7: In a read frame the block releases the pin from bit time 46 (the first turnaround bit) to the end of the frame. It samples the pin on each rising management-clock edge of bit times 48..63, and on completion the data word reads {16'h0, sampled bits}.
- R8: A read that the PHY never answers (line held high) completes normally and leaves 0x0000FFFF in the data word.
- R9: Host writes to either word while busy is 1 are ignored, and they neither change the stored fields nor start a new frame.
- R10: Both words can be read at any time. During a frame the data word still shows its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Host write strobe, one cycle per write |
| reg_addr | input | 1 | Word select: 0 data, 1 command |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven onto the data pin |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_i | input | 1 | Sampled level of the data pin |

## Verification
A behavioural model in the bench predicts the clock, the output enable, the driven bit and both readable words on every cycle. The frames tried are: writes with alternating and all-ones data to the highest PHY and register numbers, reads with PHY replies that have mixed bit patterns and with their MSB and LSB set, and a read that gets no reply at all. The alternating and edge-bit patterns show whether data is sent MSB first and whether the sampling point is one bit early or late. The silent read separates a correct release of the pin from a block that drives its own turnaround. Writes and a second command issued mid-frame show whether the busy guard really blocks changes to the stored fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned FRAME_BITS = 64;
  localparam logic [5:0]  TA_IDX     = 6'd46;
  localparam logic [5:0]  DATA_IDX   = 6'd48;
  localparam logic [5:0]  LAST_IDX   = 6'd63;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regi;
    logic       wr;
  } mdio_cmd_t;

  // Whole serial frame, bit 63 goes out first.
  function automatic logic [63:0] frame_word(mdio_cmd_t c, logic [15:0] wd);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dat;
    op  = c.wr ? 2'b01 : 2'b10;
    ta  = c.wr ? 2'b10 : 2'b11;
    dat = c.wr ? wd    : 16'hFFFF;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regi, ta, dat};
  endfunction

  function automatic logic [31:0] cmd_readback(mdio_cmd_t c, logic busy);
    return {16'h0000, c.phy, c.regi, 4'b0000, c.wr, busy};
  endfunction

  function automatic mdio_cmd_t cmd_unpack(logic [31:0] w);
    mdio_cmd_t c;
    c.phy  = w[15:11];
    c.regi = w[10:6];
    c.wr   = w[1];
    return c;
  endfunction

endpackage

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        rd_done,
  input  logic [15:0] rd_value,
  output logic [31:0] rdata,
  output mdio_cmd_t   cmd,
  output logic [15:0] tx_data,
  output logic        start
);

  logic [31:0] data_q;
  mdio_cmd_t   cmd_q;
  logic        data_wr;
  logic        unused_wbits;

  assign start   = wr_en && addr && !busy;
  assign data_wr = wr_en && !addr && !busy;
  assign unused_wbits = ^{wdata[5:2], wdata[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (start)   cmd_q  <= cmd_unpack(wdata);
      if (data_wr) data_q <= wdata;
      else if (rd_done) data_q <= {16'h0000, rd_value};
    end
  end

  assign rdata   = addr ? cmd_readback(cmd_q, busy) : data_q;
  assign cmd     = cmd_q;
  assign tx_data = data_q[15:0];

endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);

  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc  = mdc_q;
  assign rise = wrap && !mdc_q;
  assign fall = wrap &&  mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] tx_data,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic [5:0]  bit_idx,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_value
);

  logic        busy_q;
  logic [5:0]  bit_q;
  logic [15:0] shift_q;
  logic [63:0] frame_w;
  logic        last_fall;

  assign frame_w   = frame_word(cmd, tx_data);
  assign last_fall = busy_q && fall && (bit_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      shift_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (rise && !cmd.wr && (bit_q >= DATA_IDX))
        shift_q <= {shift_q[14:0], mdio_i};
      if (last_fall)
        busy_q <= 1'b0;
      else if (fall)
        bit_q <= bit_q + 6'd1;
    end
  end

  assign busy     = busy_q;
  assign bit_idx  = bit_q;
  assign mdio_o   = busy_q ? frame_w[6'd63 - bit_q] : 1'b1;
  assign mdio_oe  = busy_q && (cmd.wr || (bit_q < TA_IDX));
  assign rd_done  = last_fall && !cmd.wr;
  assign rd_value = shift_q;

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  mdio_cmd_t   cmd_w;
  logic [15:0] tx_data_w;
  logic        start_w;
  logic        busy_w;
  logic [5:0]  bit_idx_w;
  logic        rise_w;
  logic        fall_w;
  logic        rd_done_w;
  logic [15:0] rd_value_w;

  mdio_host_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy_w),
    .rd_done  (rd_done_w),
    .rd_value (rd_value_w),
    .rdata    (reg_rdata),
    .cmd      (cmd_w),
    .tx_data  (tx_data_w),
    .start    (start_w)
  );

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_w),
    .mdc   (mdc),
    .rise  (rise_w),
    .fall  (fall_w)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .cmd      (cmd_w),
    .tx_data  (tx_data_w),
    .rise     (rise_w),
    .fall     (fall_w),
    .mdio_i   (mdio_i),
    .busy     (busy_w),
    .bit_idx  (bit_idx_w),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done_w),
    .rd_value (rd_value_w)
  );

endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic        reg_addr,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [5:0]  bit_idx,
  input logic [10:0] cmd_bits
);

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr && !busy) |=> busy);

  assert_idle_mdc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_idle_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_bits[0] && (bit_idx >= 6'd46)) |-> !mdio_oe);

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en) |=> $stable(cmd_bits));

endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .busy      (busy_w),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .bit_idx   (bit_idx_w),
  .cmd_bits  (cmd_w)
);

// File: tb/tb_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_cmd_ctrl;

  localparam int DIV  = 40;
  localparam int HALF = DIV / 2;
  localparam int LEN  = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state (as it stands after the last rising clock)
  bit          m_act = 1'b0;
  int          m_t = 0;
  bit          m_wr = 1'b0;
  logic [4:0]  m_phy = '0;
  logic [4:0]  m_reg = '0;
  logic [31:0] m_data = '0;
  bit          frame_q[$];
  // PHY model
  bit          phy_answers = 1'b0;
  logic [15:0] phy_resp = '0;
  logic        phy_bit;

  always #2.5 clk = ~clk;

  mdio_cmd_ctrl #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_comb begin
    int b;
    b = m_t / DIV;
    phy_bit = 1'b1;
    if (m_act && !m_wr && phy_answers) begin
      if (b == 47) phy_bit = 1'b0;
      else if (b >= 48) phy_bit = phy_resp[63 - b];
    end
  end
  assign mdio_i = mdio_oe ? mdio_o : phy_bit;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic build_frame();
    frame_q.delete();
    for (int i = 0; i < 32; i++) frame_q.push_back(1'b1);
    frame_q.push_back(1'b0); frame_q.push_back(1'b1);
    if (m_wr) begin frame_q.push_back(1'b0); frame_q.push_back(1'b1); end
    else      begin frame_q.push_back(1'b1); frame_q.push_back(1'b0); end
    for (int i = 4; i >= 0; i--) frame_q.push_back(m_phy[i]);
    for (int i = 4; i >= 0; i--) frame_q.push_back(m_reg[i]);
    frame_q.push_back(1'b1); frame_q.push_back(1'b0);
    for (int i = 15; i >= 0; i--) frame_q.push_back(m_data[i]);
  endtask

  // model update on the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_wr = 0; m_phy = '0; m_reg = '0; m_data = '0;
    end else if (m_act) begin
      m_t++;
      if (m_t == LEN) begin
        m_act = 0;
        if (!m_wr) m_data = {16'h0, phy_answers ? phy_resp : 16'hFFFF};
      end
    end else if (reg_wr_en) begin
      if (reg_addr) begin
        m_wr = reg_wdata[1]; m_phy = reg_wdata[15:11]; m_reg = reg_wdata[10:6];
        m_act = 1; m_t = 0;
        build_frame();
      end else begin
        m_data = reg_wdata;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] exp_rd;
      bit e_mdc, e_oe;
      int b;
      b = m_t / DIV;
      e_mdc = m_act && ((m_t % DIV) >= HALF);
      e_oe  = m_act && (m_wr || b < 46);
      exp_rd = reg_addr ? {16'h0, m_phy, m_reg, 4'b0, m_wr, m_act} : m_data;
      check("R4 mdc", {31'h0, mdc}, {31'h0, e_mdc});
      check("R6/R7 oe", {31'h0, mdio_oe}, {31'h0, e_oe});
      check("R10 rdata", reg_rdata, exp_rd);
      if (e_oe) check("R5/R6 mdio_o", {31'h0, mdio_o}, {31'h0, frame_q[b]});
    end
  end

  task automatic bus_write(logic a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic wait_idle();
    reg_addr = 1'b1;
    for (int i = 0; i < 4 * LEN; i++) begin
      @(negedge clk);
      if (reg_rdata[0] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] cmdw(logic [4:0] p, logic [4:0] r, logic w);
    return {16'h0, p, r, 4'b0, w, 1'b1};
  endfunction

  task automatic do_read(logic [4:0] p, logic [4:0] r, bit ans, logic [15:0] v, string req);
    phy_answers = ans; phy_resp = v;
    bus_write(1'b1, cmdw(p, r, 1'b0));
    wait_idle();
    reg_addr = 1'b0;
    @(negedge clk);
    check(req, reg_rdata, {16'h0, ans ? v : 16'hFFFF});
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 data", reg_rdata, 32'h0);
    reg_addr = 1'b1; @(negedge clk);
    check("R1 cmd", reg_rdata, 32'h0);
    check("R1 mdc/oe", {30'h0, mdc, mdio_oe}, 32'h0);

    // write frame, alternating data
    bus_write(1'b0, 32'h0000_A5C3);
    bus_write(1'b1, cmdw(5'd3, 5'd5, 1'b1));
    @(negedge clk);
    check("R3 busy set at once", {31'h0, reg_rdata[0]}, 32'h1);
    check("R2 cmd fields", reg_rdata, {16'h0, 5'd3, 5'd5, 4'b0, 1'b1, 1'b1});
    // R9 writes while busy ignored
    bus_write(1'b0, 32'h1234_5678);
    bus_write(1'b1, cmdw(5'd7, 5'd9, 1'b0));
    @(negedge clk);
    check("R9 cmd unchanged", reg_rdata, {16'h0, 5'd3, 5'd5, 4'b0, 1'b1, 1'b1});
    reg_addr = 1'b0; @(negedge clk);
    check("R9 R10 data during busy", reg_rdata, 32'h0000_A5C3);
    wait_idle();
    check("R3 busy cleared", {31'h0, reg_rdata[0]}, 32'h0);

    // reads with replies, and a silent PHY
    do_read(5'd1, 5'd2, 1'b1, 16'h3C96, "R7 read 3C96");
    do_read(5'd4, 5'd17, 1'b0, 16'h0000, "R8 no response");
    do_read(5'd0, 5'd0, 1'b1, 16'h8001, "R7 read 8001");

    // write, all-ones data, top addresses
    bus_write(1'b0, 32'hFFFF_0001);
    bus_write(1'b1, cmdw(5'd31, 5'd31, 1'b1));
    wait_idle();
    reg_addr = 1'b0; @(negedge clk);
    check("R6 data kept after write", reg_rdata, 32'hFFFF_0001);
    bus_write(1'b0, 32'h0000_FFFF);
    bus_write(1'b1, cmdw(5'd16, 5'd1, 1'b1));
    wait_idle();
    check("R4 mdc low when idle", {31'h0, mdc}, 32'h0);
    repeat (5) @(negedge clk);
    summary();
  end

endmodule